// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers. The bus lines are oversampled by the system clock. The slave pulls SDA low through an open-drain enable and never drives it high. Each register comes out of reset at a per-bit default value. Selected bits are read-only and always keep that default.

Every register is presented on a flat parallel output so that neighbouring logic can use its contents. A one-cycle strobe marks each register as a byte is written into it.

The command byte that follows the device address sets the access type. When its top bit is set, the lower seven bits pick one register for a single-byte read or write. When its top bit is clear, the access is a block transfer that starts at register 0. On a block write, the first data byte is a byte count and is not stored. On a block read, the slave returns the register count before the register contents.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, `regs_o` equals the default vector. With the default parameters, registers 0..7 are 00, FF, 7F, E3, 00, 00, 05, 3F (register n occupies `regs_o[8n+7:8n]`). `sda_oe_o` is 0.
- R2: The 7-bit address 69h is acknowledged, which makes the byte D2h for a write and D3h for a read. Any other address byte gets no acknowledge, and the slave ignores the bus until the next start condition.
- R3: A command byte with bit 7 = 1 selects single-byte access at offset bits 6:0. In a byte write, the data byte that follows is stored in that register.
- R4: A byte read (address+W, command, repeated start, address+R) returns the selected register most significant bit first. The master then NACKs and sends a stop.
- R5: In a block write (command 00h), the first data byte is a count and is not stored. The data bytes that follow go to registers 0, 1, 2… in ascending order. A stop after any complete byte ends the transfer, and later registers keep their values.
- R6: In a block read, the slave first returns the register count (08h by default), then registers from 0 upward. It keeps sending while the master ACKs and stops after the master's NACK.
- R7: Read-only bits ignore writes and keep their default value. By default these are bits 7:3 of register 5 and bits 3:0 of register 6.
- R8: For each data byte stored in an implemented register, `wr_stb_o` pulses bit n for one clock cycle, where n is that register. No other write produces a pulse, and register contents change only in a strobe cycle.
- R9: A byte write to an offset at or beyond the register count is acknowledged but changes nothing and pulses no strobe. A read from such an offset returns 00h.
- R10: `sda_oe_o` (1 = pull SDA low) changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| regs_o | output | NUM_REGS*8 | Register contents, register n at bits 8n+7:8n |
| wr_stb_o | output | NUM_REGS | One-cycle write strobe per register |

## Verification
The checks assume a well-formed bus. SDA changes only while SCL is low, except at start and stop conditions. Each SCL level is held long enough for the two-stage synchronizer and the state register to settle before the opposite edge arrives. The master never issues a stop while the slave owns SDA. The bench master holds each SCL phase for eight clock cycles and moves SDA four cycles after the falling edge of SCL, which keeps every transaction inside these assumptions.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } smb_state_e;

    typedef struct packed {
        smb_state_e st;
        logic [7:0] shift;
        logic [3:0] bits;
        logic       rnw;
        logic       block;
        logic       count_due;
        logic [6:0] ptr;
        logic       oe;
        logic       master_ack;
        logic       wr;
        logic [6:0] waddr;
        logic [7:0] wdata;
    } smb_proto_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int W = STAGES + 1;

    logic [W-1:0] scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[W-2:0], scl_i};
        sda_d = {sda_q[W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign sda_o      = sda_q[W-2];
    assign scl_rise_o = scl_q[W-2] & ~scl_q[W-1];
    assign scl_fall_o = ~scl_q[W-2] & scl_q[W-1];
    assign start_o    = scl_q[W-2] & scl_q[W-1] & sda_q[W-1] & ~sda_q[W-2];
    assign stop_o     = scl_q[W-2] & scl_q[W-1] & ~sda_q[W-1] & sda_q[W-2];

endmodule

// File: rtl/smb_proto.sv
module smb_proto
    import smb_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sda_s,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic [NUM_REGS*8-1:0] regs_i,
    output logic                  sda_oe_o,
    output logic                  wr_o,
    output logic [6:0]            waddr_o,
    output logic [7:0]            wdata_o
);
    localparam int IDXW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    smb_proto_t q, d;
    logic [IDXW-1:0] idx;
    logic            in_range;
    logic [7:0]      tx_byte;
    logic [6:0]      tx_ptr;
    logic            tx_due;

    always_comb begin
        idx      = q.ptr[IDXW-1:0];
        in_range = 32'(q.ptr) < NUM_REGS;
        tx_due   = q.count_due;
        tx_ptr   = q.ptr;
        if (q.block && q.count_due) begin
            tx_byte = 8'(NUM_REGS);
            tx_due  = 1'b0;
        end else begin
            tx_byte = in_range ? regs_i[idx*8 +: 8] : 8'h00;
            tx_ptr  = 7'(q.ptr + 7'd1);
        end

        d    = q;
        d.wr = 1'b0;
        if (start_det) begin
            d.st   = ST_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise) begin
                        d.shift = {q.shift[6:0], sda_s};
                        d.bits  = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        d.bits = '0;
                        d.oe   = 1'b1;
                        if (q.st == ST_ADDR) begin
                            if (q.shift[7:1] == DEV_ADDR) begin
                                d.rnw = q.shift[0];
                                d.st  = ST_ADDR_ACK;
                            end else begin
                                d.oe = 1'b0;
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_CMD) begin
                            d.block     = ~q.shift[7];
                            d.count_due = ~q.shift[7];
                            d.ptr       = q.shift[7] ? q.shift[6:0] : 7'd0;
                            d.st        = ST_CMD_ACK;
                        end else begin
                            if (q.block && q.count_due) begin
                                d.count_due = 1'b0;
                            end else begin
                                d.wr    = in_range;
                                d.waddr = q.ptr;
                                d.wdata = q.shift;
                                d.ptr   = 7'(q.ptr + 7'd1);
                            end
                            d.st = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (q.rnw) begin
                            d.shift     = tx_byte;
                            d.oe        = ~tx_byte[7];
                            d.ptr       = tx_ptr;
                            d.count_due = tx_due;
                            d.st        = ST_RDATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bits == 4'd8) begin
                            d.bits = '0;
                            d.oe   = 1'b0;
                            d.st   = ST_RDATA_ACK;
                        end else begin
                            d.shift = {q.shift[6:0], 1'b0};
                            d.oe    = ~q.shift[6];
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        d.master_ack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.master_ack) begin
                            d.shift     = tx_byte;
                            d.oe        = ~tx_byte[7];
                            d.ptr       = tx_ptr;
                            d.count_due = tx_due;
                            d.st        = ST_RDATA;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign wr_o     = q.wr;
    assign waddr_o  = q.waddr;
    assign wdata_o  = q.wdata;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int                    NUM_REGS  = 8,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = '0,
    parameter logic [NUM_REGS*8-1:0] RO_MASK   = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [6:0]            waddr_i,
    input  logic [7:0]            wdata_i,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [NUM_REGS-1:0]   wr_stb_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] DEF = RESET_VAL[g*8 +: 8];
        localparam logic [7:0] RO  = RO_MASK[g*8 +: 8];

        logic [7:0] val_d, val_q;
        logic       stb_d, stb_q;

        always_comb begin
            val_d = val_q;
            stb_d = 1'b0;
            if (wr_i && waddr_i == 7'(g)) begin
                val_d = (wdata_i & ~RO) | (val_q & RO);
                stb_d = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= DEF;
                stb_q <= 1'b0;
            end else begin
                val_q <= val_d;
                stb_q <= stb_d;
            end
        end

        assign regs_o[g*8 +: 8] = val_q;
        assign wr_stb_o[g]      = stb_q;
    end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
    parameter int                    NUM_REGS    = 8,
    parameter logic [6:0]            DEV_ADDR    = 7'h69,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL   = 64'h3F05_0000_E37F_FF00,
    parameter logic [NUM_REGS*8-1:0] RO_MASK     = 64'h000F_F800_0000_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [NUM_REGS-1:0]   wr_stb_o
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr;
    logic [6:0] waddr;
    logic [7:0] wdata;

    smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    smb_proto #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) i_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .regs_i    (regs_o),
        .sda_oe_o  (sda_oe_o),
        .wr_o      (wr),
        .waddr_o   (waddr),
        .wdata_o   (wdata)
    );

    smb_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .RESET_VAL (RESET_VAL),
        .RO_MASK   (RO_MASK)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr),
        .waddr_i  (waddr),
        .wdata_i  (wdata),
        .regs_o   (regs_o),
        .wr_stb_o (wr_stb_o)
    );

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] RO_MASK  = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] regs_o,
    input logic [NUM_REGS-1:0]   wr_stb_o
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);  // R10

    AST_STB_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_o));  // R8

    AST_REG_CHANGE_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o != $past(regs_o)) |-> (wr_stb_o != '0));  // R8

    AST_RO_BITS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_o ^ $past(regs_o)) & RO_MASK) == '0);  // R7

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .regs_o   (regs_o),
    .wr_stb_o (wr_stb_o)
);

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;
    localparam int H = 8;
    localparam int NR = 8;
    localparam logic [7:0] DEF [NR] = '{8'h00, 8'hFF, 8'h7F, 8'hE3, 8'h00, 8'h00, 8'h05, 8'h3F};
    localparam logic [7:0] RO  [NR] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF8, 8'h0F, 8'h00};
    // {offset, data written, value expected afterwards}
    localparam logic [23:0] VEC [6] = '{
        {8'h00, 8'hA5, 8'hA5},
        {8'h03, 8'h5A, 8'h5A},
        {8'h07, 8'hC3, 8'hC3},
        {8'h05, 8'hFF, 8'h07},
        {8'h06, 8'hAA, 8'hA5},
        {8'h01, 8'h00, 8'h00}
    };

    logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
    logic sda_oe;
    logic [NR*8-1:0] regs;
    logic [NR-1:0] stb;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0, stb_cnt = 0, r10_viol = 0;
    logic [NR-1:0] stb_last = '0;
    logic prev_oe = 0;
    logic [7:0] mdl [NR];

    smb_cfg_slave i_smb_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .regs_o(regs), .wr_stb_o(stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && stb != '0) begin
        stb_cnt++;
        stb_last = stb;
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && sda_oe != prev_oe && scl) r10_viol++;
        prev_oe = sda_oe;
    end

    task automatic tick(int n); repeat (n) @(negedge clk); endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        sda_m = b; tick(Q); scl = 1; tick(H); scl = 0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1; tick(Q); scl = 1; tick(Q); b = sda_line; tick(Q); scl = 0; tick(Q);
    endtask

    task automatic start_c();
        sda_m = 1; tick(Q); scl = 1; tick(H); sda_m = 0; tick(H); scl = 0; tick(Q);
    endtask

    task automatic stop_c();
        sda_m = 0; tick(Q); scl = 1; tick(H); sda_m = 1; tick(H);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(x);
        ack = ~x;
    endtask

    task automatic rbyte(input logic ack_it, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) recv_bit(b[i]);
        send_bit(~ack_it);
    endtask

    function automatic logic [7:0] merge(int r, logic [7:0] d);
        return (d & ~RO[r]) | (mdl[r] & RO[r]);
    endfunction

    function automatic logic [63:0] mdl_flat();
        logic [63:0] f;
        for (int i = 0; i < NR; i++) f[i*8 +: 8] = mdl[i];
        return f;
    endfunction

    task automatic byte_write(logic [7:0] off, logic [7:0] d, string req);
        logic a0, a1, a2;
        start_c(); wbyte(8'hD2, a0); wbyte({1'b1, off[6:0]}, a1); wbyte(d, a2); stop_c();
        check(req, {a0, a1, a2}, 3'b111);
    endtask

    task automatic byte_read(logic [7:0] off, output logic [7:0] d);
        logic a0, a1, a2;
        start_c(); wbyte(8'hD2, a0); wbyte({1'b1, off[6:0]}, a1);
        start_c(); wbyte(8'hD3, a2); rbyte(1'b0, d); stop_c();
        check("R2 ack on byte read", {a0, a1, a2}, 3'b111);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic a, a1, a2;
        int n0;
        for (int i = 0; i < NR; i++) mdl[i] = DEF[i];
        tick(5); rst_n = 1; tick(5);
        check("R1 reset registers", regs, mdl_flat());
        check("R1 reset sda_oe", sda_oe, 0);

        // R3 R4 R7 R8 vector walk
        foreach (VEC[k]) begin
            logic [7:0] off, dat, exp;
            {off, dat, exp} = VEC[k];
            n0 = stb_cnt;
            byte_write(off, dat, "R3 byte write ack");
            mdl[off] = merge(off, dat);
            check("R7 model agrees with vector", mdl[off], exp);
            check("R3 R7 register output", regs[off*8 +: 8], exp);
            check("R8 one strobe", stb_cnt - n0, 1);
            check("R8 strobe index", stb_last, 8'(1) << off);
            byte_read(off, rd);
            check("R4 byte read value", rd, exp);
        end

        // R2 wrong address: NACK and ignored
        start_c(); wbyte(8'hA4, a); wbyte(8'h82, a1); wbyte(8'h11, a2); stop_c();
        check("R2 nack foreign address", {a, a1, a2}, 3'b000);
        check("R2 registers untouched", regs, mdl_flat());

        // R9 out of range offset
        n0 = stb_cnt;
        byte_write(8'h10, 8'h77, "R9 out of range ack");
        check("R9 no change", regs, mdl_flat());
        check("R9 no strobe", stb_cnt - n0, 0);
        byte_read(8'h10, rd);
        check("R9 read returns zero", rd, 0);

        // R5 block write of three bytes
        n0 = stb_cnt;
        start_c(); wbyte(8'hD2, a); wbyte(8'h00, a1); wbyte(8'h03, a2);
        check("R5 block header ack", {a, a1, a2}, 3'b111);
        wbyte(8'h11, a); wbyte(8'h22, a1); wbyte(8'h33, a2); stop_c();
        check("R5 block data ack", {a, a1, a2}, 3'b111);
        mdl[0] = 8'h11; mdl[1] = 8'h22; mdl[2] = 8'h33;
        check("R5 block write result", regs, mdl_flat());
        check("R8 three strobes", stb_cnt - n0, 3);

        // R5 early stop after first data byte
        start_c(); wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h08, a); wbyte(8'h44, a); stop_c();
        mdl[0] = 8'h44;
        check("R5 early stop", regs, mdl_flat());

        // R6 block read
        start_c(); wbyte(8'hD2, a); wbyte(8'h00, a1); start_c(); wbyte(8'hD3, a2);
        check("R6 block read ack", {a, a1, a2}, 3'b111);
        rbyte(1'b1, rd);
        check("R6 byte count", rd, NR);
        for (int i = 0; i < NR; i++) begin
            rbyte(i != NR - 1, rd);
            check("R6 block read data", rd, mdl[i]);
        end
        stop_c();
        check("R6 bus released", sda_oe, 0);

        check("R10 no SDA change while SCL high", r10_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule